// File: doc/BRIEF.md
# DVFS operating point sequencer

This block steps one power-supply domain between a fixed set of operating levels. Each level pairs a clock-frequency select code with the lowest supply-voltage code that is safe for that frequency. A request names a target level. The block then drives the voltage code to an external regulator and the frequency select to a clock divider or PLL mux. It orders every move so that the domain never runs a frequency above what its present voltage supports.

When the block moves up, it raises the voltage first, one table entry at a time, and changes the frequency last. When it moves down, it lowers the frequency first and then walks the voltage down entry by entry. After each voltage step it waits for the regulator to report ready. After each frequency change it waits either for the clock to report lock or for a programmed number of cycles. Each domain gets its own instance, so several domains can sit at different levels.

The request input is a single-cycle strobe with no back-pressure: every strobe is taken, and a later strobe replaces the stored target. A strobe that arrives in the middle of a step does not cut that step short. The block finishes the step and then heads for the newest target.

Top module: `dvfs_seq`

## Requirements
- R1: While reset is held and right after it, the outputs show the reset level (default level 0: voltage code 90, frequency select 24), and busy and done are both low.
- R2: Level i (0 to NUM_LVL-1) maps to voltage code V_LO + floor((V_HI-V_LO)*i/(NUM_LVL-1)) and frequency select F_LO + floor((F_HI-F_LO)*i/(NUM_LVL-1)). With the defaults this gives voltage 90..120 and frequency select 24..40. When a request completes, both outputs show the codes of the target level.
- R3: A requested level above NUM_LVL-1 is treated as NUM_LVL-1.
- R4: At every cycle the level of the frequency select is at or below the level of the voltage code. On an upward move, every voltage step comes before the single frequency change.
- R5: The voltage code moves by exactly one table entry per step. The number of voltage changes in a move equals the distance between the levels, and voltage and frequency never change in the same cycle.
- R6: On a downward move, the frequency changes to the target level before the first voltage change.
- R7: After a voltage step, no further change happens until vreg_ready is seen high, and the first cycle after the step is ignored.
- R8: With use_lock high, a frequency change is followed by a wait for clk_lock. With use_lock low, clk_lock is ignored and the next step starts exactly settle_cycles+1 cycles after the frequency change, where a count of 0 acts as 1.
- R9: A request that arrives while busy is accepted. The step in progress completes, and the block ends at the newest target with a single done pulse.
- R10: done is a one-cycle pulse, raised once the outputs match the target while vreg_ready is high and (if use_lock is high) clk_lock is high. busy is high from the request until done and low while done is high.
- R11: A request for the present level produces done with no change on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Target request strobe, always accepted |
| req_level | input | IDX_W+1 | Requested level, clamped to the top level |
| vreg_ready | input | 1 | Regulator reports output settled |
| clk_lock | input | 1 | Clock source reports lock |
| use_lock | input | 1 | 1: wait for clk_lock after a frequency change; 0: use the settle count |
| settle_cycles | input | CNT_W | Settle wait in cycles when use_lock is low |
| volt_code | output | VW | Voltage code to the regulator |
| freq_sel | output | FW | Frequency select to the clock source |
| busy | output | 1 | A move is pending or in progress |
| done | output | 1 | One-cycle pulse when the target is reached |

## Verification
A table of requests is walked from level 0: upward, downward, to the same level, and to an out-of-range level, each under either lock or counted settling. A monitor maps every output code back to a level. This shows whether each move stepped the voltage one entry at a time and placed the single frequency change on the correct side of the voltage steps. Directed cases hold the regulator ready or the clock lock low to show the block stalls at the right point. They also measure the exact gap of the counted settle for a long count and for a zero count, with lock held low to show it is ignored. One case retargets a move in mid-flight to show that exactly one done pulse marks the final target.

// File: rtl/dvfs_seq_pkg.sv
package dvfs_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VWAIT = 2'd1,
    ST_FWAIT = 2'd2
  } seq_st_e;

  typedef enum logic {
    WK_VOLT = 1'b0,
    WK_FREQ = 1'b1
  } wait_kind_e;

  // Linear interpolation used to fill the operating point table.
  function automatic int unsigned lerp(input int unsigned lo, input int unsigned hi,
                                       input int unsigned idx, input int unsigned last);
    return lo + ((hi - lo) * idx) / last;
  endfunction

endpackage

// File: rtl/dvfs_op_table.sv
module dvfs_op_table #(
  parameter int NUM_LVL = 8,
  parameter int IDX_W   = 3,
  parameter int VW      = 8,
  parameter int FW      = 6,
  parameter int V_LO    = 90,
  parameter int V_HI    = 120,
  parameter int F_LO    = 24,
  parameter int F_HI    = 40
) (
  input  logic [IDX_W-1:0] v_idx,
  input  logic [IDX_W-1:0] f_idx,
  output logic [VW-1:0]    v_code,
  output logic [FW-1:0]    f_code
);
  localparam int unsigned LAST = (NUM_LVL > 1) ? NUM_LVL - 1 : 1;

  logic [VW-1:0] vtab [NUM_LVL];
  logic [FW-1:0] ftab [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    localparam int unsigned VC = dvfs_seq_pkg::lerp(V_LO, V_HI, g, LAST);
    localparam int unsigned FC = dvfs_seq_pkg::lerp(F_LO, F_HI, g, LAST);
    assign vtab[g] = VW'(VC);
    assign ftab[g] = FW'(FC);
  end

  assign v_code = vtab[v_idx];
  assign f_code = ftab[f_idx];

endmodule

// File: rtl/dvfs_req_latch.sv
module dvfs_req_latch #(
  parameter int NUM_LVL = 8,
  parameter int IDX_W   = 3,
  parameter int RST_LVL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W:0]   req_level,
  input  logic             clr_pend,
  output logic [IDX_W-1:0] tgt,
  output logic             pend
);
  localparam logic [IDX_W:0] TOP = (IDX_W+1)'(NUM_LVL - 1);

  logic [IDX_W-1:0] tgt_n;

  // Out-of-range requests settle on the highest level.
  always_comb begin
    if (req_level > TOP) tgt_n = TOP[IDX_W-1:0];
    else                 tgt_n = req_level[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt  <= IDX_W'(RST_LVL);
      pend <= 1'b0;
    end else begin
      if (req_valid) begin
        tgt  <= tgt_n;
        pend <= 1'b1;
      end else if (clr_pend) begin
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer
  import dvfs_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  wait_kind_e       kind,
  input  logic             vreg_ready,
  input  logic             clk_lock,
  input  logic             use_lock,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             fin
);
  logic             active;
  logic             first;
  wait_kind_e       kind_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load;
  logic             timed;
  logic             hs;

  assign load  = (settle_cycles == '0) ? CNT_W'(1) : settle_cycles;
  assign timed = (kind_q == WK_FREQ) && !use_lock;
  assign hs    = (kind_q == WK_VOLT) ? vreg_ready : clk_lock;
  assign fin   = active && (timed ? (cnt == CNT_W'(1)) : (!first && hs));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b0;
      kind_q <= WK_VOLT;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      first  <= 1'b1;
      kind_q <= kind;
      cnt    <= load;
    end else if (active) begin
      first <= 1'b0;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      if (fin) active <= 1'b0;
    end
  end

endmodule

// File: rtl/dvfs_step_ctrl.sv
module dvfs_step_ctrl
  import dvfs_seq_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int RST_LVL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] tgt,
  input  logic             pend,
  input  logic             req_valid,
  input  logic             vreg_ready,
  input  logic             clk_lock,
  input  logic             use_lock,
  input  logic             fin,
  output logic [IDX_W-1:0] v_idx,
  output logic [IDX_W-1:0] f_idx,
  output logic             start,
  output wait_kind_e       start_kind,
  output logic             in_wait,
  output logic             busy,
  output logic             done,
  output logic             done_set
);
  seq_st_e st_q;
  logic    at_tgt, do_f, do_vup, do_vdn, hs_ok, idle;

  assign idle   = (st_q == ST_IDLE);
  assign at_tgt = (v_idx == tgt) && (f_idx == tgt);
  assign hs_ok  = vreg_ready && (!use_lock || clk_lock);

  // Frequency moves first whenever the present voltage already covers the
  // target; otherwise the voltage walks one entry toward the target.
  always_comb begin
    do_f   = (f_idx > tgt) || ((f_idx < tgt) && (v_idx >= tgt));
    do_vup = !do_f && (v_idx < tgt);
    do_vdn = !do_f && (v_idx > tgt);
  end

  assign start      = idle && (do_f || do_vup || do_vdn);
  assign start_kind = do_f ? WK_FREQ : WK_VOLT;
  assign done_set   = idle && pend && at_tgt && hs_ok && !req_valid;
  assign in_wait    = !idle;
  assign busy       = !idle || pend || !at_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      v_idx <= IDX_W'(RST_LVL);
      f_idx <= IDX_W'(RST_LVL);
      done  <= 1'b0;
    end else begin
      done <= done_set;
      unique case (st_q)
        ST_IDLE: begin
          if (do_f) begin
            f_idx <= tgt;
            st_q  <= ST_FWAIT;
          end else if (do_vup) begin
            v_idx <= v_idx + IDX_W'(1);
            st_q  <= ST_VWAIT;
          end else if (do_vdn) begin
            v_idx <= v_idx - IDX_W'(1);
            st_q  <= ST_VWAIT;
          end
        end
        ST_VWAIT, ST_FWAIT: begin
          if (fin) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
  parameter int NUM_LVL = 8,
  parameter int VW      = 8,
  parameter int FW      = 6,
  parameter int CNT_W   = 8,
  parameter int V_LO    = 90,
  parameter int V_HI    = 120,
  parameter int F_LO    = 24,
  parameter int F_HI    = 40,
  parameter int RST_LVL = 0,
  localparam int IDX_W  = $clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W:0]   req_level,
  input  logic             vreg_ready,
  input  logic             clk_lock,
  input  logic             use_lock,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic [VW-1:0]    volt_code,
  output logic [FW-1:0]    freq_sel,
  output logic             busy,
  output logic             done
);
  import dvfs_seq_pkg::*;

  logic [IDX_W-1:0] tgt;
  logic             pend;
  logic [IDX_W-1:0] v_idx;
  logic [IDX_W-1:0] f_idx;
  logic             start;
  wait_kind_e       start_kind;
  logic             fin;
  logic             in_wait;
  logic             done_set;

  dvfs_req_latch #(
    .NUM_LVL(NUM_LVL), .IDX_W(IDX_W), .RST_LVL(RST_LVL)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .clr_pend(done_set), .tgt(tgt), .pend(pend)
  );

  dvfs_step_ctrl #(
    .IDX_W(IDX_W), .RST_LVL(RST_LVL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .pend(pend), .req_valid(req_valid),
    .vreg_ready(vreg_ready), .clk_lock(clk_lock), .use_lock(use_lock), .fin(fin),
    .v_idx(v_idx), .f_idx(f_idx), .start(start), .start_kind(start_kind),
    .in_wait(in_wait), .busy(busy), .done(done), .done_set(done_set)
  );

  dvfs_settle_timer #(
    .CNT_W(CNT_W)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(start_kind),
    .vreg_ready(vreg_ready), .clk_lock(clk_lock), .use_lock(use_lock),
    .settle_cycles(settle_cycles), .fin(fin)
  );

  dvfs_op_table #(
    .NUM_LVL(NUM_LVL), .IDX_W(IDX_W), .VW(VW), .FW(FW),
    .V_LO(V_LO), .V_HI(V_HI), .F_LO(F_LO), .F_HI(F_HI)
  ) u_tab (
    .v_idx(v_idx), .f_idx(f_idx), .v_code(volt_code), .f_code(freq_sel)
  );

endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             in_wait,
  input logic [IDX_W-1:0] v_idx,
  input logic [IDX_W-1:0] f_idx
);

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    f_idx <= v_idx);

  p_vstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_idx) |-> ((v_idx == $past(v_idx) + IDX_W'(1)) ||
                         (v_idx + IDX_W'(1) == $past(v_idx))));

  p_onechg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_idx) |-> $stable(f_idx));

  p_nomid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_wait) |-> ($stable(v_idx) && $stable(f_idx)));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind dvfs_seq dvfs_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .in_wait(in_wait), .v_idx(v_idx), .f_idx(f_idx)
);

// File: tb/test_dvfs_seq.sv
module test_dvfs_seq;
  localparam int NL  = 8;
  localparam int RW  = 4;
  localparam int REG_DLY  = 3;
  localparam int LOCK_DLY = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [RW-1:0] req_level = '0;
  logic          vreg_ready = 1'b1;
  logic          clk_lock = 1'b1;
  logic          use_lock = 1'b1;
  logic [7:0]    settle_cycles = 8'd3;
  logic [7:0]    volt_code;
  logic [5:0]    freq_sel;
  logic          busy;
  logic          done;

  int total = 0;
  int bad = 0;
  bit reg_hold = 0;
  bit lock_hold = 0;

  // monitor state (written only by the monitor)
  int cyc = 0;
  int vchg = 0, fchg = 0, ord_bad = 0, step_bad = 0, both_bad = 0, code_bad = 0;
  int dn_cnt = 0, vchg_at_f = 0, last_f_cyc = 0, last_v_cyc = 0;

  always #2 clk = ~clk;

  dvfs_seq i_dvfs_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .vreg_ready(vreg_ready), .clk_lock(clk_lock), .use_lock(use_lock),
    .settle_cycles(settle_cycles), .volt_code(volt_code), .freq_sel(freq_sel),
    .busy(busy), .done(done)
  );

  function automatic int exp_v(input int i);
    return 90 + (30 * i) / (NL - 1);
  endfunction
  function automatic int exp_f(input int i);
    return 24 + (16 * i) / (NL - 1);
  endfunction
  function automatic int v_lvl(input logic [7:0] c);
    for (int i = 0; i < NL; i++) if (exp_v(i) == int'(c)) return i;
    return -1;
  endfunction
  function automatic int f_lvl(input logic [5:0] c);
    for (int i = 0; i < NL; i++) if (exp_f(i) == int'(c)) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Regulator model: ready drops for REG_DLY cycles after a code change.
  initial begin
    logic [7:0] lv;
    int cnt;
    lv = 8'd90; cnt = 0;
    forever begin
      @(negedge clk);
      if (volt_code != lv) begin lv = volt_code; cnt = REG_DLY; end
      else if (cnt > 0) cnt--;
      vreg_ready = (cnt == 0) && !reg_hold;
    end
  end

  // Clock model: lock drops for LOCK_DLY cycles after a select change.
  initial begin
    logic [5:0] lf;
    int cnt;
    lf = 6'd24; cnt = 0;
    forever begin
      @(negedge clk);
      if (freq_sel != lf) begin lf = freq_sel; cnt = LOCK_DLY; end
      else if (cnt > 0) cnt--;
      clk_lock = (cnt == 0) && !lock_hold;
    end
  end

  // Output monitor.
  initial begin
    int pv, pf, vi, fi;
    bit started;
    started = 0; pv = 0; pf = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        vi = v_lvl(volt_code);
        fi = f_lvl(freq_sel);
        if (done) dn_cnt++;
        if (vi < 0 || fi < 0) code_bad++;
        if (fi > vi) ord_bad++;
        if (started) begin
          if (vi != pv && vi != pv + 1 && vi != pv - 1) step_bad++;
          if (vi != pv && fi != pf) both_bad++;
          if (vi != pv) begin vchg++; last_v_cyc = cyc; end
          if (fi != pf) begin fchg++; last_f_cyc = cyc; vchg_at_f = vchg; end
        end
        started = 1; pv = vi; pf = fi;
      end
    end
  end

  task automatic issue(input int lvl);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = RW'(lvl);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int limit, output bit seen);
    seen = 0;
    for (int k = 0; k < limit; k++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  int cur = 0;

  task automatic run(input int req, input bit lk, input int settle);
    int fin, steps, vb, fb, ob, sb, bb, db;
    bit seen;
    use_lock = lk;
    settle_cycles = 8'(settle);
    fin = (req > NL - 1) ? NL - 1 : req;
    steps = (fin > cur) ? fin - cur : cur - fin;
    vb = vchg; fb = fchg; ob = ord_bad; sb = step_bad; bb = both_bad; db = dn_cnt;
    issue(req);
    wait_done(3000, seen);
    chk(seen, "R10", "done seen", int'(seen), 1);
    @(negedge clk);
    chk(!busy, "R10", "busy after done", int'(busy), 0);
    chk(dn_cnt - db == 1, "R10", "done pulses", dn_cnt - db, 1);
    chk(int'(volt_code) == exp_v(fin), (req > NL - 1) ? "R3" : "R2", "volt code",
        int'(volt_code), exp_v(fin));
    chk(int'(freq_sel) == exp_f(fin), (req > NL - 1) ? "R3" : "R2", "freq sel",
        int'(freq_sel), exp_f(fin));
    chk(vchg - vb == steps, "R5", "voltage steps", vchg - vb, steps);
    chk(step_bad == sb && both_bad == bb && code_bad == 0, "R5", "step shape",
        step_bad - sb + both_bad - bb + code_bad, 0);
    chk(ord_bad == ob, "R4", "freq above voltage", ord_bad - ob, 0);
    if (fin == cur) begin
      chk(fchg == fb && vchg == vb, "R11", "changes on same-level request",
          fchg - fb + vchg - vb, 0);
    end else begin
      chk(fchg - fb == 1, "R5", "freq changes", fchg - fb, 1);
      if (fin > cur)
        chk(vchg_at_f == vb + steps, "R4", "voltage steps before freq", vchg_at_f - vb, steps);
      else
        chk(vchg_at_f == vb, "R6", "voltage steps before freq", vchg_at_f - vb, 0);
    end
    cur = fin;
  endtask

  // {use_lock, requested level}
  localparam logic [4:0] VEC [8] = '{
    {1'b1, 4'd3}, {1'b1, 4'd7}, {1'b0, 4'd1}, {1'b0, 4'd5},
    {1'b1, 4'd0}, {1'b1, 4'd15}, {1'b0, 4'd4}, {1'b1, 4'd4}
  };

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    bit seen;
    int vb, fb, db;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(int'(volt_code) == exp_v(0), "R1", "reset volt", int'(volt_code), exp_v(0));
    chk(int'(freq_sel) == exp_f(0), "R1", "reset freq", int'(freq_sel), exp_f(0));
    chk(!busy, "R1", "reset busy", int'(busy), 0);
    chk(!done, "R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && int'(volt_code) == exp_v(0), "R1", "after reset",
        int'(volt_code), exp_v(0));

    for (int n = 0; n < 8; n++) run(int'(VEC[n][3:0]), VEC[n][4], 3);

    // R8: counted settle with lock held low, long count
    lock_hold = 1;
    repeat (8) @(negedge clk);
    run(3, 1'b0, 20);
    chk(last_v_cyc - last_f_cyc == 21, "R8", "settle gap 20", last_v_cyc - last_f_cyc, 21);
    // R8: zero count acts as one
    run(2, 1'b0, 0);
    chk(last_v_cyc - last_f_cyc == 2, "R8", "settle gap 0", last_v_cyc - last_f_cyc, 2);

    // R8: lock mode stalls until clk_lock
    db = dn_cnt;
    use_lock = 1'b1;
    issue(3);
    repeat (40) @(negedge clk);
    chk(busy && dn_cnt == db, "R8", "stall on lock", int'(busy), 1);
    chk(int'(freq_sel) == exp_f(3), "R8", "freq before lock", int'(freq_sel), exp_f(3));
    lock_hold = 0;
    wait_done(500, seen);
    chk(seen, "R8", "done after lock", int'(seen), 1);
    cur = 3;
    repeat (10) @(negedge clk);

    // R7: regulator ready held low
    reg_hold = 1;
    vb = vchg; fb = fchg;
    issue(6);
    repeat (40) @(negedge clk);
    chk(int'(volt_code) == exp_v(4), "R7", "one step while not ready",
        int'(volt_code), exp_v(4));
    chk(vchg - vb == 1 && fchg == fb && busy, "R7", "held changes", vchg - vb, 1);
    reg_hold = 0;
    wait_done(500, seen);
    chk(seen && int'(volt_code) == exp_v(6), "R7", "final volt after ready",
        int'(volt_code), exp_v(6));
    cur = 6;
    repeat (10) @(negedge clk);

    // R9: retarget while busy
    db = dn_cnt;
    vb = ord_bad;
    issue(1);
    repeat (3) @(negedge clk);
    issue(7);
    wait_done(3000, seen);
    repeat (20) @(negedge clk);
    chk(dn_cnt - db == 1, "R9", "single done", dn_cnt - db, 1);
    chk(int'(volt_code) == exp_v(7) && int'(freq_sel) == exp_f(7), "R9", "newest target",
        int'(volt_code), exp_v(7));
    chk(ord_bad == vb && step_bad == 0 && both_bad == 0, "R9", "ordering kept",
        ord_bad - vb, 0);
    chk(!busy, "R9", "idle at end", int'(busy), 0);

    summary();
  end

endmodule